// File: doc/BRIEF.md
# NAND Sector Hamming Check Generator

This block watches the data moving between a controller and a NAND flash array and folds every accepted byte into a 24-bit Hamming check code for one sector. The code is twelve parity pairs. Three pairs describe the position of a bit inside its byte. Nine pairs describe the byte's address inside the sector, which runs to at most 512 bytes. Data arrives as 8-bit words, or as 16-bit words that each carry two bytes. Software starts a sector by pulsing `clear` and programs the sector length as half the byte count minus one. When the last word of the sector has been taken, the block holds the finished code until the next `clear`. It offers the code as a raw 32-bit word and as three packed check bytes.

A small state machine drives the block. Its states are `ST_IDLE` (after reset, no sector open), `ST_RUN` (accumulating) and `ST_HOLD` (sector complete, result frozen). It has four transitions:
- IDLE→RUN on `clear`.
- RUN→HOLD when the final word of the sector is accepted.
- HOLD→RUN on `clear`.
- RUN→RUN on `clear`, which restarts the sector.

The code is not inverted. An erased sector, with every byte 0xFF, therefore yields an all-zero code.

Top module: `hecc_sector_gen`

## Requirements
- R1: After reset `raw_out` and `packed_out` are zero, and `done` and `busy` are low.
- R2: A `clear` sampled at a clock edge zeroes every parity, zeroes the byte address and makes `busy` high from that edge on. A `strobe` in the same cycle as `clear` contributes nothing.
- R3: Bit-position parity k (k = 0, 1, 2, weights 1, 2, 4) has an even half and an odd half. The even half is the XOR of every data bit whose index inside its byte has bit k clear. The odd half is the XOR of every data bit whose index has bit k set.
- R4: Address parity j (j = 0..8, weights 8 to 2048) has an even half and an odd half. The even half is the XOR of every data bit of the bytes whose sector byte address has bit j clear. The odd half covers the bytes whose address has bit j set. Addresses count from 0 at `clear`.
- R5: `raw_out` carries the even halves in bits 0–11 and the odd halves in bits 16–27. Within each half the order is weight 1, 2, 4, then 8 to 2048. All other bits are zero.
- R6: `packed_out[7:0]` is even bits 0–7. `packed_out[15:8]` is odd bits 0–7. `packed_out[19:16]` is even bits 8–11 and `packed_out[23:20]` is odd bits 8–11.
- R7: A sector is `(size_cfg+1)*2` bytes. On the clock edge that accepts its last word, `busy` falls and `done` rises. `done` and `busy` are never high together.
- R8: With `wide_mode` high, `data_in[7:0]` is the byte at the current (even) address and `data_in[15:8]` is the byte at the next address. With `wide_mode` low, only `data_in[7:0]` is used, and `data_in[15:8]` has no effect.
- R9: A `strobe` while idle or holding leaves `raw_out` unchanged. The result and `done` stay fixed until the next `clear`.
- R10: Cycles with `strobe` low add nothing. A sector of all-0xFF bytes gives an all-zero code in both widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Zero the parities and open a new sector |
| wide_mode | input | 1 | 1: 16-bit words, two bytes each; 0: 8-bit words |
| size_cfg | input | 8 | Sector length as bytes/2 − 1 |
| strobe | input | 1 | `data_in` holds a valid word this cycle |
| data_in | input | 16 | Data word on the flash bus |
| busy | output | 1 | Sector open and accumulating |
| done | output | 1 | Sector complete, result held |
| raw_out | output | 32 | Even parities in [11:0], odd parities in [27:16] |
| packed_out | output | 24 | Three check bytes in storage order |

## Verification
Every position of a single set bit in an 8-byte sector is swept in both bus widths. This gives each bit-position pair and the low address pairs a distinct signature, so a swapped or mis-weighted parity stands out. Pseudo-random full 512-byte sectors exercise the upper address pairs, including 1024 and 2048. The same data is then replayed as 16-bit words with idle gaps, which separates byte-lane ordering errors and gap handling from the parity logic. Erased sectors check the non-inverted convention. Strobes while holding or idle, a strobe under `clear`, a restart in mid-sector and an odd sector length probe the control sequencing.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } hecc_state_e;

    localparam int BIT_PAIRS = 3;
endpackage

// File: rtl/hecc_lane_par.sv
// Parity contribution of one byte at one sector address.
module hecc_lane_par #(
    parameter int ADDR_W = 9,
    parameter int NP     = hecc_pkg::BIT_PAIRS + ADDR_W
) (
    input  logic [7:0]        byte_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_i,
    output logic [NP-1:0]     ev_o,
    output logic [NP-1:0]     od_o
);
    logic byte_xor;
    assign byte_xor = ^byte_i;

    always_comb begin
        ev_o = '0;
        od_o = '0;
        if (en_i) begin
            for (int k = 0; k < hecc_pkg::BIT_PAIRS; k++) begin
                for (int b = 0; b < 8; b++) begin
                    if (((b >> k) & 1) != 0) od_o[k] = od_o[k] ^ byte_i[b];
                    else                     ev_o[k] = ev_o[k] ^ byte_i[b];
                end
            end
            for (int j = 0; j < ADDR_W; j++) begin
                if (addr_i[j]) od_o[hecc_pkg::BIT_PAIRS+j] = byte_xor;
                else           ev_o[hecc_pkg::BIT_PAIRS+j] = byte_xor;
            end
        end
    end
endmodule

// File: rtl/hecc_seq.sv
// Sector sequencer: state machine and byte address counter.
module hecc_seq #(
    parameter int ADDR_W = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       strobe,
    input  logic                       wide_mode,
    input  logic [ADDR_W-2:0]          size_cfg,
    output hecc_pkg::hecc_state_e      state_o,
    output logic                       take_o,
    output logic [ADDR_W-1:0]          addr_o
);
    import hecc_pkg::*;

    hecc_state_e state_q, state_d;
    logic [ADDR_W:0] cnt_q;
    logic [ADDR_W:0] words_n;
    logic [ADDR_W:0] total;
    logic [ADDR_W:0] step;
    logic            last;

    assign words_n = {2'b00, size_cfg} + 1'b1;
    assign total   = {words_n[ADDR_W-1:0], 1'b0};
    assign step    = wide_mode ? (ADDR_W+1)'(2) : (ADDR_W+1)'(1);
    assign take_o  = (state_q == ST_RUN) && strobe && !clear;
    assign last    = take_o && ((cnt_q + step) == total);
    assign state_o = state_q;
    assign addr_o  = cnt_q[ADDR_W-1:0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (clear) state_d = ST_RUN;
            ST_RUN:  if (clear) state_d = ST_RUN;
                     else if (last) state_d = ST_HOLD;
            ST_HOLD: if (clear) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (take_o) cnt_q <= cnt_q + step;
    end
endmodule

// File: rtl/hecc_sector_gen.sv
module hecc_sector_gen #(
    parameter int SECTOR_MAX = 512,
    parameter int DATA_W     = 16,
    localparam int ADDR_W    = $clog2(SECTOR_MAX),
    localparam int LANES     = DATA_W / 8,
    localparam int NP        = hecc_pkg::BIT_PAIRS + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wide_mode,
    input  logic [ADDR_W-2:0] size_cfg,
    input  logic              strobe,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic              done,
    output logic [31:0]       raw_out,
    output logic [23:0]       packed_out
);
    import hecc_pkg::*;

    hecc_state_e       state;
    logic              take;
    logic [ADDR_W-1:0] base_addr;
    logic [NP-1:0]     lane_ev [LANES];
    logic [NP-1:0]     lane_od [LANES];
    logic [NP-1:0]     sum_ev, sum_od;
    logic [NP-1:0]     acc_ev, acc_od;

    hecc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .strobe    (strobe),
        .wide_mode (wide_mode),
        .size_cfg  (size_cfg),
        .state_o   (state),
        .take_o    (take),
        .addr_o    (base_addr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_en;
        assign lane_en = take && ((g == 0) || wide_mode);
        hecc_lane_par #(.ADDR_W(ADDR_W), .NP(NP)) u_par (
            .byte_i (data_in[8*g +: 8]),
            .addr_i (base_addr | ADDR_W'(g)),
            .en_i   (lane_en),
            .ev_o   (lane_ev[g]),
            .od_o   (lane_od[g])
        );
    end

    always_comb begin
        sum_ev = '0;
        sum_od = '0;
        for (int l = 0; l < LANES; l++) begin
            sum_ev = sum_ev ^ lane_ev[l];
            sum_od = sum_od ^ lane_od[l];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_ev <= '0;
            acc_od <= '0;
        end else if (clear) begin
            acc_ev <= '0;
            acc_od <= '0;
        end else if (take) begin
            acc_ev <= acc_ev ^ sum_ev;
            acc_od <= acc_od ^ sum_od;
        end
    end

    assign busy       = (state == ST_RUN);
    assign done       = (state == ST_HOLD);
    assign raw_out    = {{(16-NP){1'b0}}, acc_od, {(16-NP){1'b0}}, acc_ev};
    assign packed_out = {acc_od[11:8], acc_ev[11:8], acc_od[7:0], acc_ev[7:0]};
endmodule

// File: rtl/hecc_sector_chk.sv
module hecc_sector_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clear,
    input logic        strobe,
    input logic        busy,
    input logic        done,
    input logic [31:0] raw_out
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (raw_out == 32'h0) && !done && !busy);

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (raw_out == 32'h0) && busy);

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_done_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(strobe) && $past(busy));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !clear |=> done && $stable(raw_out));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !done && !clear |=> $stable(raw_out));
endmodule

bind hecc_sector_gen hecc_sector_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done),
    .raw_out (raw_out)
);

// File: tb/hecc_sector_gen_test.sv
module hecc_sector_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        wide_mode = 1'b0;
    logic [7:0]  size_cfg = 8'd0;
    logic        strobe = 1'b0;
    logic [15:0] data_in = 16'h0;
    logic        busy, done;
    logic [31:0] raw_out;
    logic [23:0] packed_out;

    int total = 0;
    int bad = 0;
    logic [7:0] mem [0:511];
    int seed = 32'h1234_5678;

    always #5 clk = ~clk;

    hecc_sector_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .wide_mode  (wide_mode),
        .size_cfg   (size_cfg),
        .strobe     (strobe),
        .data_in    (data_in),
        .busy       (busy),
        .done       (done),
        .raw_out    (raw_out),
        .packed_out (packed_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Bit-level model: each set bit toggles one half of every pair.
    function automatic logic [23:0] model(input int n);
        logic [11:0] ev = '0;
        logic [11:0] od = '0;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (mem[i][b]) begin
                    for (int k = 0; k < 3; k++)
                        if (((b >> k) & 1) != 0) od[k] = ~od[k]; else ev[k] = ~ev[k];
                    for (int j = 0; j < 9; j++)
                        if (((i >> j) & 1) != 0) od[3+j] = ~od[3+j]; else ev[3+j] = ~ev[3+j];
                end
            end
        end
        return {od, ev};
    endfunction

    task automatic fill_random(input int n);
        for (int i = 0; i < n; i++) begin
            seed = seed * 1103515245 + 12345;
            mem[i] = seed[23:16];
        end
    endtask

    task automatic run_sector(input logic wide, input int cfg, input bit gaps, input string req);
        int nbytes = (cfg + 1) * 2;
        int nwords = wide ? nbytes / 2 : nbytes;
        logic [23:0] m;
        @(negedge clk);
        wide_mode = wide; size_cfg = 8'(cfg); clear = 1'b1; strobe = 1'b0;
        @(negedge clk);
        clear = 1'b0;
        check("R2 busy after clear", {31'b0, busy}, 32'd1);
        check("R2 zero after clear", raw_out, 32'h0);
        for (int w = 0; w < nwords; w++) begin
            if (gaps && (w % 3 == 1)) begin
                strobe = 1'b0;
                data_in = 16'hFFFF;
                @(negedge clk);
            end
            strobe = 1'b1;
            if (wide) data_in = {mem[2*w+1], mem[2*w]};
            else      data_in = {8'(w * 37 + 5), mem[w]};   // R8: high byte is junk
            if (w == nwords - 1) check("R7 done low before last", {31'b0, done}, 32'd0);
            @(negedge clk);
        end
        strobe = 1'b0;
        m = model(nbytes);
        check({req, " raw R5"}, raw_out, {4'b0, m[23:12], 4'b0, m[11:0]});
        check({req, " packed R6"}, {8'b0, packed_out}, {8'b0, m[23:20], m[11:8], m[19:12], m[7:0]});
        check("R7 done", {30'b0, done, busy}, 32'd2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R1 raw", raw_out, 32'h0);
        check("R1 packed", {8'b0, packed_out}, 32'h0);
        check("R1 flags", {30'b0, done, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        strobe = 1'b1; data_in = 16'hBEEF;
        @(negedge clk);
        strobe = 1'b0;
        check("R9 idle strobe ignored", raw_out, 32'h0);

        // R3/R4 sweep of one set bit over a short sector, both widths
        for (int pos = 0; pos < 64; pos++) begin
            for (int i = 0; i < 8; i++) mem[i] = 8'h00;
            mem[pos / 8][pos % 8] = 1'b1;
            run_sector(1'b0, 3, 1'b0, "R3 R4 single bit narrow");
            run_sector(1'b1, 3, 1'b0, "R3 R4 single bit wide");
        end

        // Full sectors, random data, narrow then wide with gaps
        fill_random(512);
        run_sector(1'b0, 255, 1'b0, "R4 full narrow");
        run_sector(1'b1, 255, 1'b1, "R8 R10 full wide gaps");

        // R9: strobes while holding
        held = raw_out;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            strobe = 1'b1; data_in = 16'(i * 4099 + 1);
        end
        @(negedge clk);
        strobe = 1'b0;
        check("R9 hold raw", raw_out, held);
        check("R9 hold done", {31'b0, done}, 32'd1);

        // R10: erased sector
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        run_sector(1'b0, 255, 1'b0, "R10 erased narrow");
        check("R10 erased zero", raw_out, 32'h0);
        run_sector(1'b1, 255, 1'b0, "R10 erased wide");
        check("R10 erased zero wide", raw_out, 32'h0);

        // R2: strobe under clear, and restart mid-sector
        @(negedge clk);
        clear = 1'b1; strobe = 1'b1; data_in = 16'h0001;
        @(negedge clk);
        clear = 1'b0; strobe = 1'b0;
        check("R2 strobe under clear", raw_out, 32'h0);
        for (int i = 0; i < 5; i++) begin
            strobe = 1'b1; data_in = 16'h5A3C;
            @(negedge clk);
        end
        strobe = 1'b0;
        fill_random(202);
        run_sector(1'b0, 100, 1'b1, "R7 odd length narrow");
        run_sector(1'b1, 100, 1'b0, "R7 odd length wide");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule